// File: doc/BRIEF.md
# Speculative Posit Operand Decoder

The block takes one N-bit posit word per handshake and splits it into a sign, a signed combined scale (regime and exponent together) and a two's complement significand that carries the hidden bit. It works on the raw two's complement word. Negative operands are not negated first. Their significand comes out as `10.f`, read as -2 + f, and their scale is adjusted to match. Positive operands come out as `01.f`. The value of a normal result is `signed(outSig) * 2^(outScale - FW)`, where FW = N-3-ES.

Most operands in practice have a regime of exactly two bits. For those, every field sits at a fixed position. A fast path decodes the word at those positions as soon as it arrives. A check runs alongside it and tests whether the two bits after the sign differ. If they do, the fast result is registered after one cycle. If they do not, the fast result is thrown away. The word is then held, `inReady` drops for one cycle, and a leading-run counter plus shifter produces the result one cycle later. The all-zero word and the NaR word (a one followed by zeros) skip the decode and are flagged after one cycle.

The outputs have no backpressure. `outValid` is a one-cycle pulse. The other outputs keep their values until the next result. The parameters are N (word width, at least 5) and ES (exponent bits, at least 1), with defaults 16 and 1.

Top module: `posit_dec`

## Requirements
- R1: After reset, `outValid` is low and `inReady` is high.
- R2: An accepted word of all zeros gives `outZero`=1 and `outNaR`=0, with `outSign`, `outScale` and `outSig` all zero, one cycle after acceptance.
- R3: An accepted word with bit N-1 set and all other bits clear gives `outNaR`=1 and `outZero`=0, with `outSign`, `outScale` and `outSig` all zero, one cycle after acceptance.
- R4: Bits N-2 and N-3 of a non-special word may differ (two-bit regime). In that case, `outValid` rises in the cycle right after acceptance with the fully decoded result.
- R5: Bits N-2 and N-3 of a non-special word may be equal (longer regime). In that case, `inReady` is low in the cycle after acceptance, no result appears in that cycle, and the result appears two cycles after acceptance.
- R6: `outSign` equals bit N-1 of the word. `outSig` is FW+2 bits wide and holds {sign, not sign, fraction}. The fraction bits that follow the exponent are placed left-aligned and zero-padded. So `signed(outSig)*2^(outScale-FW)` equals the posit's value.
- R7: Let r be bits N-2..0 of the word. Let m be the length of the leading run of bits equal to r's top bit. The regime value k is m-1 for a run of ones and -m for a run of zeros. The exponent e is the ES bits after the terminating bit, zero-padded when cut short. With T = k*2^ES + e, `outScale` is T for a positive word and -(T+1) for a negative word.
- R8: Each accepted word produces exactly one `outValid` pulse, and results leave in acceptance order. There is no pulse without an accepted word.
- R9: While only two-bit-regime or special words arrive, `inReady` stays high, so one word is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Word offered |
| inReady | output | 1 | Block can take a word this cycle |
| inWord | input | N | Posit word, two's complement |
| outValid | output | 1 | One-cycle pulse: result fields are new |
| outZero | output | 1 | Result is the zero word |
| outNaR | output | 1 | Result is NaR |
| outSign | output | 1 | Sign bit of the word |
| outScale | output | $clog2(N<<ES)+2 | Signed combined scale |
| outSig | output | N-1-ES | Two's complement significand {s, ~s, fraction} |

## Verification
The bench sends all 65536 words of the default format. It checks each result against a decoder that first takes the magnitude and then converts back to the two's complement form, so the two sides reach the answer by different routes.

The words where the two methods most easily disagree are these:
- Negative words with a zero fraction. Here the scale must drop by one. A design that gets this wrong is off by a factor of two.
- Words whose run fills the whole word, such as the largest and smallest magnitudes. A shifter that mishandles the end shows garbage fraction or exponent bits.
- Words whose exponent is cut off. Missing zero padding shows there too.

Each result is also timed against its acceptance cycle. A speculation check that passes long regimes on to the fast path shows up as a wrong value one cycle early. A stall that lasts too long, or that ends too early, shows up as a latency or `inReady` mismatch. Zero and NaR are checked on the fast timing, with cleared fields.

// File: rtl/posit_dec_pkg.sv
package posit_dec_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFast;     // register the fixed-position decode of inWord
    logic captureSlow;  // hold inWord for the run-counting path
    logic loadSlow;     // register the run-counting decode of the held word
  } dec_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SLOW = 1'b1
  } dec_state_t;

endpackage

// File: rtl/posit_run_counter.sv
// Length of the leading run of bits equal to the top bit.
// The result is at least 1 and at most W.
module posit_run_counter #(
  parameter int W = 15,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  bitsIn,
  output logic [CW-1:0] runLen
);

  logic [W-1:0] diffBits;

  assign diffBits = bitsIn ^ {W{bitsIn[W-1]}};

  always_comb begin
    runLen = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (diffBits[i]) runLen = CW'(W - 1 - i);
    end
  end

endmodule

// File: rtl/posit_dec_ctrl.sv
module posit_dec_ctrl
  import posit_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        fastHit,
  output logic        inReady,
  output dec_strobe_t strobe
);

  dec_state_t state;
  logic       accept;

  assign inReady = (state == ST_IDLE);
  assign accept  = inValid && inReady;

  always_comb begin
    strobe             = '0;
    strobe.loadFast    = accept && fastHit;
    strobe.captureSlow = accept && !fastHit;
    strobe.loadSlow    = (state == ST_SLOW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (strobe.captureSlow) begin
      state <= ST_SLOW;
    end else if (state == ST_SLOW) begin
      state <= ST_IDLE;
    end
  end

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SLOW |=> state == ST_IDLE); // R5
  AST_CAPTURE_THEN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureSlow |=> strobe.loadSlow && !strobe.loadFast); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R8

endmodule

// File: rtl/posit_dec_datapath.sv
module posit_dec_datapath
  import posit_dec_pkg::*;
#(
  parameter int N  = 16,
  parameter int ES = 1,
  localparam int RW = N - 1,
  localparam int FW = N - 3 - ES,
  localparam int SW = $clog2(N << ES) + 2,
  localparam int CW = $clog2(RW + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  inWord,
  input  dec_strobe_t   strobe,
  output logic          fastHit,
  output logic          outValid,
  output logic          outZero,
  output logic          outNaR,
  output logic          outSign,
  output logic [SW-1:0] outScale,
  output logic [FW+1:0] outSig
);

  // -(T+1) is the bitwise complement of T
  function automatic logic [SW-1:0] mkScale(input logic s, input logic [SW-1:0] k,
                                           input logic [ES-1:0] e);
    logic [SW-1:0] t;
    t = (k << ES) + SW'(e);
    return s ? ~t : t;
  endfunction

  // early special detection
  logic restZero, isSpecial;
  assign restZero  = (inWord[N-2:0] == '0);
  assign isSpecial = restZero;

  // speculative fixed-position decode, regime assumed two bits
  logic          regimeIsTwo;
  logic [SW-1:0] kFast, scaleFast;
  logic [FW+1:0] sigFast;

  assign regimeIsTwo = inWord[N-2] ^ inWord[N-3];
  assign fastHit     = isSpecial || regimeIsTwo;
  assign kFast       = inWord[N-2] ? '0 : '1;
  assign scaleFast   = mkScale(inWord[N-1], kFast, inWord[N-4 -: ES]);
  assign sigFast     = {inWord[N-1], ~inWord[N-1], inWord[FW-1:0]};

  // run-counting decode of the held word
  logic [N-1:0]  heldWord;
  logic [CW-1:0] runLen;
  logic [N-4:0]  body;
  logic [SW-1:0] kSlow, scaleSlow;
  logic [FW+1:0] sigSlow;

  posit_run_counter #(.W(RW)) u_run (
    .bitsIn (heldWord[N-2:0]),
    .runLen (runLen)
  );

  assign body      = heldWord[N-4:0] << (runLen - CW'(1));
  assign kSlow     = heldWord[N-2] ? (SW'(runLen) - SW'(1)) : (SW'(0) - SW'(runLen));
  assign scaleSlow = mkScale(heldWord[N-1], kSlow, body[N-4 -: ES]);
  assign sigSlow   = {heldWord[N-1], ~heldWord[N-1], body[FW-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldWord <= '0;
    end else if (strobe.captureSlow) begin
      heldWord <= inWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outZero  <= 1'b0;
      outNaR   <= 1'b0;
      outSign  <= 1'b0;
      outScale <= '0;
      outSig   <= '0;
    end else begin
      outValid <= strobe.loadFast || strobe.loadSlow;
      if (strobe.loadFast) begin
        outZero  <= isSpecial && !inWord[N-1];
        outNaR   <= isSpecial && inWord[N-1];
        outSign  <= isSpecial ? 1'b0 : inWord[N-1];
        outScale <= isSpecial ? '0 : scaleFast;
        outSig   <= isSpecial ? '0 : sigFast;
      end else if (strobe.loadSlow) begin
        outZero  <= 1'b0;
        outNaR   <= 1'b0;
        outSign  <= heldWord[N-1];
        outScale <= scaleSlow;
        outSig   <= sigSlow;
      end
    end
  end

  AST_SPECIAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !(outZero && outNaR)); // R2
  AST_SPECIAL_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outZero || outNaR) |-> outScale == '0 && outSig == '0 && !outSign); // R3
  AST_HIDDEN_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outZero && !outNaR |-> outSig[FW+1] != outSig[FW] && outSig[FW+1] == outSign); // R6
  AST_SLOW_NEEDS_LONG_RUN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSlow |-> runLen >= CW'(2)); // R7

endmodule

// File: rtl/posit_dec.sv
module posit_dec
  import posit_dec_pkg::*;
#(
  parameter int N  = 16,
  parameter int ES = 1,
  localparam int FW = N - 3 - ES,
  localparam int SW = $clog2(N << ES) + 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  input  logic [N-1:0]  inWord,
  output logic          outValid,
  output logic          outZero,
  output logic          outNaR,
  output logic          outSign,
  output logic [SW-1:0] outScale,
  output logic [FW+1:0] outSig
);

  dec_strobe_t strobe;
  logic        fastHit;

  posit_dec_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .fastHit (fastHit),
    .inReady (inReady),
    .strobe  (strobe)
  );

  posit_dec_datapath #(.N(N), .ES(ES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inWord   (inWord),
    .strobe   (strobe),
    .fastHit  (fastHit),
    .outValid (outValid),
    .outZero  (outZero),
    .outNaR   (outNaR),
    .outSign  (outSign),
    .outScale (outScale),
    .outSig   (outSig)
  );

  AST_FAST_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && fastHit |=> outValid); // R4
  AST_SLOW_STALL: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !fastHit |=> !inReady && !outValid); // R5

endmodule

// File: tb/posit_dec_bench.sv
module posit_dec_bench;

  localparam int N  = 16;
  localparam int ES = 1;
  localparam int FW = N - 3 - ES;
  localparam int SW = $clog2(N << ES) + 2;

  typedef struct {
    int    due;
    int    word;
    bit    zero;
    bit    nar;
    bit    sign;
    int    scale;
    int    sig;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [N-1:0]  inWord = '0;
  logic          inReady, outValid, outZero, outNaR, outSign;
  logic [SW-1:0] outScale;
  logic [FW+1:0] outSig;

  int   nChecks = 0;
  int   nFails = 0;
  int   cyc = 0;
  bit   finished = 1'b0;
  exp_t pending[$];
  int   lastSlowCyc = -10;

  always #2 clk = ~clk;

  posit_dec #(.N(N), .ES(ES)) u_posit_dec (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outZero(outZero), .outNaR(outNaR), .outSign(outSign),
    .outScale(outScale), .outSig(outSig)
  );

  task automatic check(input bit ok, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s", what);
    end
  endtask

  // reference: magnitude decode, then conversion to the two's complement form
  function automatic exp_t refDecode(input int w);
    exp_t e;
    int s, a, b, m, k, rem, tail, padded, ex, fM, sM;
    e.word = w; e.zero = 0; e.nar = 0; e.sign = 0; e.scale = 0; e.sig = 0;
    if (w == 0) begin
      e.zero = 1; e.tag = "R2";
      return e;
    end
    if (w == (1 << (N - 1))) begin
      e.nar = 1; e.tag = "R3";
      return e;
    end
    s = (w >> (N - 1)) & 1;
    a = s ? (((1 << N) - w) & ((1 << N) - 1)) : w;
    b = (a >> (N - 2)) & 1;
    m = 0;
    for (int i = N - 2; i >= 0; i--) begin
      if (((a >> i) & 1) == b) m++;
      else break;
    end
    k = b ? m - 1 : -m;
    rem = N - 2 - m;
    if (rem < 0) rem = 0;
    tail = a & ((1 << rem) - 1);
    padded = tail << (ES + FW - rem);
    ex = padded >> FW;
    fM = padded & ((1 << FW) - 1);
    sM = k * (1 << ES) + ex;
    e.sign = s[0];
    if (s == 0) begin
      e.scale = sM; e.sig = (1 << FW) | fM;
    end else if (fM == 0) begin
      e.scale = sM - 1; e.sig = 2 << FW;
    end else begin
      e.scale = sM; e.sig = (2 << FW) | ((1 << FW) - fM);
    end
    if ((((w >> (N - 2)) ^ (w >> (N - 3))) & 1) == 1) e.tag = "R4 R6 R7";
    else e.tag = "R5 R6 R7";
    return e;
  endfunction

  // called at each negedge, after the outputs settled
  task automatic checkOut();
    exp_t e;
    if (outValid) begin
      if (pending.size() == 0) begin
        check(1'b0, $sformatf("R8 pulse without accepted word at cycle %0d: actual 1 expected 0", cyc));
      end else begin
        e = pending.pop_front();
        check(cyc == e.due, $sformatf("%s latency word %h: actual cycle %0d expected %0d",
                                      e.tag, e.word, cyc, e.due));
        check(outZero == e.zero && outNaR == e.nar && outSign == e.sign &&
              int'($signed(outScale)) == e.scale && int'(outSig) == e.sig,
              $sformatf("%s word %h: actual z%0d n%0d s%0d sc%0d sig%h expected z%0d n%0d s%0d sc%0d sig%h",
                        e.tag, e.word, outZero, outNaR, outSign, $signed(outScale), outSig,
                        e.zero, e.nar, e.sign, e.scale, e.sig));
      end
    end else if (pending.size() != 0 && pending[0].due <= cyc) begin
      check(1'b0, $sformatf("R8 missing result word %h at cycle %0d: actual 0 expected 1",
                            pending[0].word, cyc));
      void'(pending.pop_front());
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    checkOut();
  endtask

  task automatic offer(input int w);
    exp_t e;
    bit fast, expReady;
    inValid = 1'b1;
    inWord  = N'(w);
    forever begin
      expReady = (lastSlowCyc != cyc - 1);
      check(inReady == expReady, $sformatf("R5 R9 inReady at cycle %0d: actual %0d expected %0d",
                                           cyc, inReady, expReady));
      if (inReady) begin
        e = refDecode(w);
        fast = e.zero || e.nar || ((((w >> (N - 2)) ^ (w >> (N - 3))) & 1) == 1);
        e.due = cyc + (fast ? 1 : 2);
        if (!fast) lastSlowCyc = cyc;
        pending.push_back(e);
        tick();
        break;
      end
      tick();
    end
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0 && inReady == 1'b1,
          $sformatf("R1 reset state: actual valid %0d ready %0d expected 0 1", outValid, inReady));
    rstN = 1'b1;
    tick();
    // directed corners first: zero, NaR, extremes, back-to-back fast words
    offer(0);
    offer(1 << (N - 1));
    offer((1 << (N - 1)) - 1);
    offer((1 << N) - 1);
    offer((1 << (N - 1)) + 1);
    offer(1);
    offer('h4000); offer('h4001); offer('hC000); offer('hB000); offer('h2000);
    tick(); tick();
    // every pattern, with occasional idle gaps
    for (int w = 0; w < (1 << N); w++) begin
      if (w % 97 == 5) tick();
      offer(w);
    end
    repeat (4) tick();
    check(pending.size() == 0, $sformatf("R8 results outstanding at end: actual %0d expected 0",
                                         pending.size()));
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule